// File: doc/BRIEF.md
# Vector Add-with-Carry Mask Lane

This block is one element lane of a vector integer unit. It handles the four carry-chain operations: a full-width add that folds in a carry, a full-width subtract that folds in a borrow, and two mask producers that return only the carry-out or the borrow-out of the same arithmetic. The element width is chosen per operation from 8, 16, 32 or 64 bits. The second operand comes from a vector register, from a scalar register, or from a 5-bit immediate. The lane's mask bit enters the arithmetic as data. It is never used to switch the element off.

The lane also inspects the encoding fields it receives and flags the reserved combinations. It reports the tail policy that applies to the result. Every operation takes one cycle: the result appears on the registered outputs in the cycle after the input strobe. Multi-word additions are built from these lanes by the surrounding machinery. That machinery writes the carry-out mask first, then the full-width sum, and then moves the mask into the carry register. It also handles fetch, register storage and the packing of mask bits across elements.

Top module: `vcarry_lane`

## Requirements
- R1: With `op_sel`=0 (full add), `res_data` equals (A + B + `cin_bit`) modulo 2^SEW, with every bit above SEW zero. Here A is the low SEW bits of `vs2_data` and B is the selected operand. The carry-in is always used.
- R2: With `op_sel`=1 (full subtract), `res_data` equals (A − B − `cin_bit`) modulo 2^SEW, with every bit above SEW zero. The borrow-in is always used.
- R3: With `op_sel`=2 (carry-out), `res_mask` is 1 exactly when A + B + C exceeds 2^SEW − 1. C is `cin_bit` when `vm_bit`=0 and zero when `vm_bit`=1. `res_data` is zero.
- R4: With `op_sel`=3 (borrow-out), `res_mask` is 1 exactly when the untruncated A − B − C is negative. C is chosen as in R3. `res_data` is zero.
- R5: `src_sel` picks B as follows. 0 takes the low SEW bits of `vs1_data`. 1 takes the low SEW bits of `rs1_data`. 2 takes `imm5` sign-extended to SEW bits. 3 is reserved and raises `res_illegal`.
- R6: A full add or full subtract with `vm_bit`=1 raises `res_illegal`.
- R7: A full add or full subtract with `vd_idx`=0 raises `res_illegal`. The carry-out and borrow-out operations accept `vd_idx`=0.
- R8: When `res_illegal` is 1, `res_data`, `res_mask`, `res_is_mask` and `res_tail_agn` are all 0.
- R9: `res_is_mask` is 1 for legal operations 2 and 3. For those operations `res_tail_agn` is 1 regardless of `vta_bit`. For legal operations 0 and 1, `res_tail_agn` copies `vta_bit`.
- R10: `res_valid` repeats `in_valid` one cycle later. A cycle without `in_valid` clears every result output, and so does reset. `sew_sel` encodes 0=8, 1=16, 2=32, 3=64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | 0 add, 1 subtract, 2 carry-out, 3 borrow-out |
| src_sel | input | 2 | Second operand source |
| sew_sel | input | 2 | Element width code |
| vm_bit | input | 1 | Mask-enable field of the encoding |
| vta_bit | input | 1 | Tail policy requested for full-width results |
| vd_idx | input | 5 | Destination register index |
| vs2_data | input | 64 | First operand element |
| vs1_data | input | 64 | Vector second operand element |
| rs1_data | input | 64 | Scalar second operand |
| imm5 | input | 5 | Immediate second operand |
| cin_bit | input | 1 | Mask bit used as carry or borrow in |
| res_valid | output | 1 | Result strobe |
| res_data | output | 64 | Full-width result, zero-extended above SEW |
| res_mask | output | 1 | Carry-out or borrow-out bit |
| res_is_mask | output | 1 | Result is a mask bit |
| res_illegal | output | 1 | Reserved encoding detected |
| res_tail_agn | output | 1 | Tail-agnostic status |

## Verification
The bench concentrates on the carry boundary at each width. All-ones plus zero with a carry-in must produce a carry and wrap the result to zero. A lane that takes the carry from the 64-bit position at every width would miss it at the narrow widths. A lane that forgets the carry-in would return all-ones. Subtracting zero from zero with a borrow-in must report a borrow. A lane that compares only the operands would report none. The immediate −1 must fill exactly SEW bits, so a missing sign extension shows up as the value 31. Reserved encodings are crossed with destination 0, and the bench checks that the mask producers accept that destination. A decoder that treats all four operations alike would flag them or miss them.

// File: rtl/vcarry_pkg.sv
package vcarry_pkg;

    localparam int ELEN    = 64;
    localparam int NUM_SEW = 4;

    typedef enum logic [1:0] {
        SEW_8  = 2'd0,
        SEW_16 = 2'd1,
        SEW_32 = 2'd2,
        SEW_64 = 2'd3
    } sew_e;

    typedef enum logic [1:0] {
        OP_ADD_C  = 2'd0,
        OP_SUB_B  = 2'd1,
        OP_CARRY  = 2'd2,
        OP_BORROW = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SRC_VREG = 2'd0,
        SRC_XREG = 2'd1,
        SRC_IMM  = 2'd2,
        SRC_RSVD = 2'd3
    } src_e;

    typedef struct packed {
        logic illegal;
        logic is_mask;
        logic is_sub;
        logic use_cin;
    } lane_ctl_t;

    typedef struct packed {
        logic            valid;
        logic [ELEN-1:0] data;
        logic            mask;
        logic            is_mask;
        logic            illegal;
        logic            tail_agn;
    } lane_res_t;

    function automatic logic [ELEN-1:0] width_mask(sew_e s);
        return {ELEN{1'b1}} >> (ELEN - (8 << s));
    endfunction

    function automatic logic is_full_width(op_e o);
        return (o == OP_ADD_C) || (o == OP_SUB_B);
    endfunction

endpackage

// File: rtl/vcarry_decode.sv
module vcarry_decode
    import vcarry_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  op_e              op,
    input  src_e             src,
    input  logic             vm,
    input  logic [REG_W-1:0] vd,
    output lane_ctl_t        ctl
);
    logic full_op;
    logic bad_src;
    logic bad_vm;
    logic bad_vd;

    always_comb begin
        full_op = is_full_width(op);
        bad_src = (src == SRC_RSVD);
        bad_vm  = full_op && vm;
        bad_vd  = full_op && (vd == '0);

        ctl.illegal = bad_src || bad_vm || bad_vd;
        ctl.is_mask = !full_op;
        ctl.is_sub  = (op == OP_SUB_B) || (op == OP_BORROW);
        // full-width ops always consume the mask bit; mask producers only when vm=0
        ctl.use_cin = full_op ? 1'b1 : !vm;
    end
endmodule

// File: rtl/vcarry_operand.sv
module vcarry_operand
    import vcarry_pkg::*;
#(
    parameter int IMM_W = 5
) (
    input  sew_e             sew,
    input  src_e             src,
    input  logic [ELEN-1:0]  vs2,
    input  logic [ELEN-1:0]  vs1,
    input  logic [ELEN-1:0]  rs1,
    input  logic [IMM_W-1:0] imm,
    output logic [ELEN-1:0]  opa,
    output logic [ELEN-1:0]  opb
);
    localparam int EXT_W = ELEN - IMM_W;

    logic [ELEN-1:0] wmask;
    logic [ELEN-1:0] imm_ext;
    logic [ELEN-1:0] raw_b;

    always_comb begin
        wmask   = width_mask(sew);
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        unique case (src)
            SRC_VREG: raw_b = vs1;
            SRC_XREG: raw_b = rs1;
            SRC_IMM:  raw_b = imm_ext;
            default:  raw_b = '0;
        endcase
        opa = vs2 & wmask;
        opb = raw_b & wmask;
    end
endmodule

// File: rtl/vcarry_adder.sv
module vcarry_adder
    import vcarry_pkg::*;
(
    input  sew_e            sew,
    input  logic [ELEN-1:0] opa,
    input  logic [ELEN-1:0] opb,
    input  logic            cin,
    input  logic            is_sub,
    output logic [ELEN-1:0] sum,
    output logic            cout
);
    logic [ELEN-1:0] sum_w  [NUM_SEW];
    logic            cout_w [NUM_SEW];

    for (genvar g = 0; g < NUM_SEW; g++) begin : g_width
        localparam int W = 8 << g;
        logic [W:0] ext;
        always_comb begin
            if (is_sub)
                ext = {1'b0, opa[W-1:0]} - {1'b0, opb[W-1:0]} - {{W{1'b0}}, cin};
            else
                ext = {1'b0, opa[W-1:0]} + {1'b0, opb[W-1:0]} + {{W{1'b0}}, cin};
            sum_w[g]  = ELEN'(ext[W-1:0]);
            // bit W: carry for add, sign of the untruncated difference for subtract
            cout_w[g] = ext[W];
        end
    end

    always_comb begin
        sum  = sum_w[sew];
        cout = cout_w[sew];
    end
endmodule

// File: rtl/vcarry_lane.sv
module vcarry_lane
    import vcarry_pkg::*;
#(
    parameter int IMM_W = 5,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       op_sel,
    input  logic [1:0]       src_sel,
    input  logic [1:0]       sew_sel,
    input  logic             vm_bit,
    input  logic             vta_bit,
    input  logic [REG_W-1:0] vd_idx,
    input  logic [63:0]      vs2_data,
    input  logic [63:0]      vs1_data,
    input  logic [63:0]      rs1_data,
    input  logic [IMM_W-1:0] imm5,
    input  logic             cin_bit,
    output logic             res_valid,
    output logic [63:0]      res_data,
    output logic             res_mask,
    output logic             res_is_mask,
    output logic             res_illegal,
    output logic             res_tail_agn
);
    op_e             op;
    src_e            src;
    sew_e            sew;
    lane_ctl_t       ctl;
    logic [ELEN-1:0] opa;
    logic [ELEN-1:0] opb;
    logic [ELEN-1:0] sum;
    logic            cout;
    logic            eff_cin;
    lane_res_t       nxt;
    lane_res_t       res_q;

    assign op  = op_e'(op_sel);
    assign src = src_e'(src_sel);
    assign sew = sew_e'(sew_sel);

    vcarry_decode #(.REG_W(REG_W)) dec_i (
        .op (op), .src (src), .vm (vm_bit), .vd (vd_idx), .ctl (ctl)
    );

    vcarry_operand #(.IMM_W(IMM_W)) opnd_i (
        .sew (sew), .src (src), .vs2 (vs2_data), .vs1 (vs1_data),
        .rs1 (rs1_data), .imm (imm5), .opa (opa), .opb (opb)
    );

    assign eff_cin = ctl.use_cin & cin_bit;

    vcarry_adder add_i (
        .sew (sew), .opa (opa), .opb (opb), .cin (eff_cin),
        .is_sub (ctl.is_sub), .sum (sum), .cout (cout)
    );

    always_comb begin
        nxt = '0;
        if (in_valid) begin
            nxt.valid   = 1'b1;
            nxt.illegal = ctl.illegal;
            if (!ctl.illegal) begin
                nxt.is_mask  = ctl.is_mask;
                nxt.data     = ctl.is_mask ? '0 : sum;
                nxt.mask     = ctl.is_mask ? cout : 1'b0;
                nxt.tail_agn = ctl.is_mask ? 1'b1 : vta_bit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= nxt;
    end

    assign res_valid    = res_q.valid;
    assign res_data     = res_q.data;
    assign res_mask     = res_q.mask;
    assign res_is_mask  = res_q.is_mask;
    assign res_illegal  = res_q.illegal;
    assign res_tail_agn = res_q.tail_agn;

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    // R10
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && res_data == '0 && !res_illegal));

    // R6
    vm_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_sel[1] && vm_bit) |=> res_illegal);

    // R7
    v0_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_sel[1] && vd_idx == '0) |=> res_illegal);

    // R8
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        res_illegal |-> (res_data == '0 && !res_mask && !res_is_mask && !res_tail_agn));

    // R9
    mask_tail_chk: assert property (@(posedge clk) disable iff (rst)
        res_is_mask |-> (res_tail_agn && res_data == '0));

    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sew_sel != 2'd3) |=> (res_data >> (8 << $past(sew_sel))) == '0);
endmodule

// File: tb/vcarry_lane_tb_top.sv
module vcarry_lane_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op_sel, src_sel, sew_sel;
    logic        vm_bit, vta_bit, cin_bit;
    logic [4:0]  vd_idx, imm5;
    logic [63:0] vs2_data, vs1_data, rs1_data;
    logic        res_valid, res_mask, res_is_mask, res_illegal, res_tail_agn;
    logic [63:0] res_data;

    int n_checks = 0;
    int n_fail   = 0;

    logic        e_valid, e_mask, e_is_mask, e_illegal, e_tail;
    logic [63:0] e_data;
    string       e_tag_data, e_tag_mask, e_tag_ill;

    always #4 clk = ~clk;

    vcarry_lane dut_i (
        .clk (clk), .rst (rst), .in_valid (in_valid), .op_sel (op_sel),
        .src_sel (src_sel), .sew_sel (sew_sel), .vm_bit (vm_bit), .vta_bit (vta_bit),
        .vd_idx (vd_idx), .vs2_data (vs2_data), .vs1_data (vs1_data),
        .rs1_data (rs1_data), .imm5 (imm5), .cin_bit (cin_bit),
        .res_valid (res_valid), .res_data (res_data), .res_mask (res_mask),
        .res_is_mask (res_is_mask), .res_illegal (res_illegal), .res_tail_agn (res_tail_agn)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural model of the requirements for the currently driven inputs
    task automatic predict();
        int unsigned w;
        logic [63:0] lim, a, b, c;
        logic [65:0] wide;
        logic full;
        w    = 8 << sew_sel;
        lim  = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        full = (op_sel < 2);
        e_valid = in_valid; e_data = 0; e_mask = 0; e_is_mask = 0; e_illegal = 0; e_tail = 0;
        e_tag_data = (op_sel == 0) ? "R1" : (op_sel == 1) ? "R2" : "R9";
        e_tag_mask = (op_sel == 2) ? "R3" : (op_sel == 3) ? "R4" : "R9";
        e_tag_ill  = (src_sel == 3) ? "R5" : (full && vm_bit) ? "R6" : "R7";
        if (!in_valid) begin
            e_tag_data = "R10"; e_tag_mask = "R10"; e_tag_ill = "R10";
            return;
        end
        if (src_sel == 3 || (full && vm_bit) || (full && vd_idx == 0)) begin
            e_illegal = 1;
            e_tag_data = "R8"; e_tag_mask = "R8";
            return;
        end
        a = vs2_data & lim;
        case (src_sel)
            2'd0: b = vs1_data & lim;
            2'd1: b = rs1_data & lim;
            default: b = (imm5[4] ? (64'hFFFF_FFFF_FFFF_FFE0 | 64'(imm5)) : 64'(imm5)) & lim; // R5
        endcase
        c = (full || !vm_bit) ? 64'(cin_bit) : 64'd0;
        case (op_sel)
            2'd0: begin e_data = (a + b + c) & lim; e_tail = vta_bit; end
            2'd1: begin e_data = (a - b - c) & lim; e_tail = vta_bit; end
            2'd2: begin
                wide = 66'(a) + 66'(b) + 66'(c);
                e_mask = (wide > 66'(lim)); e_is_mask = 1; e_tail = 1;
            end
            default: begin
                e_mask = (66'(a) < 66'(b) + 66'(c)); e_is_mask = 1; e_tail = 1;
            end
        endcase
    endtask

    task automatic compare();
        chk("R10", "valid", 64'(res_valid), 64'(e_valid));
        chk(e_tag_data, "data", res_data, e_data);
        chk(e_tag_mask, "mask", 64'(res_mask), 64'(e_mask));
        chk("R9", "is_mask", 64'(res_is_mask), 64'(e_is_mask));
        chk(e_tag_ill, "illegal", 64'(res_illegal), 64'(e_illegal));
        chk("R9", "tail", 64'(res_tail_agn), 64'(e_tail));
    endtask

    task automatic drive(input logic v, input logic [1:0] op, input logic [1:0] src,
                         input logic [1:0] sew, input logic vm, input logic vta,
                         input logic [4:0] vd, input logic [63:0] a, input logic [63:0] b1,
                         input logic [63:0] r1, input logic [4:0] im, input logic ci);
        in_valid = v; op_sel = op; src_sel = src; sew_sel = sew; vm_bit = vm; vta_bit = vta;
        vd_idx = vd; vs2_data = a; vs1_data = b1; rs1_data = r1; imm5 = im; cin_bit = ci;
        predict();
        @(negedge clk);
        compare();
    endtask

    initial begin
        rst = 1'b1;
        in_valid = 0; op_sel = 0; src_sel = 0; sew_sel = 0; vm_bit = 0; vta_bit = 0;
        vd_idx = 0; vs2_data = 0; vs1_data = 0; rs1_data = 0; imm5 = 0; cin_bit = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "reset valid", 64'(res_valid), 64'd0);
        chk("R10", "reset data", res_data, 64'd0);
        chk("R10", "reset illegal", 64'(res_illegal), 64'd0);
        rst = 1'b0;

        for (int s = 0; s < 4; s++) begin
            // R1: all-ones + 0 + carry wraps to zero; R3: carry produced at each width
            drive(1, 2'd0, 2'd0, 2'(s), 0, 1, 5'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, 0, 1);
            drive(1, 2'd2, 2'd0, 2'(s), 0, 0, 5'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, 0, 1);
            drive(1, 2'd2, 2'd0, 2'(s), 1, 0, 5'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, 0, 1);
            // R4: 0 - 0 - borrow is negative; R2 wraps to all ones
            drive(1, 2'd3, 2'd0, 2'(s), 0, 0, 5'd0, 64'd0, 64'd0, 0, 0, 1);
            drive(1, 2'd1, 2'd0, 2'(s), 0, 0, 5'd7, 64'd0, 64'd0, 0, 0, 1);
            // R5: immediate -1 sign-extended to SEW
            drive(1, 2'd0, 2'd2, 2'(s), 0, 1, 5'd3, 64'd0, 0, 0, 5'h1F, 0);
            drive(1, 2'd3, 2'd1, 2'(s), 1, 0, 5'd0, 64'd5, 0, 64'd5, 0, 1);
        end
        // R6, R7, R5 reserved forms and an idle cycle
        drive(1, 2'd0, 2'd0, 2'd2, 1, 1, 5'd2, 64'd9, 64'd1, 0, 0, 1);
        drive(1, 2'd1, 2'd1, 2'd1, 0, 1, 5'd0, 64'd9, 0, 64'd1, 0, 0);
        drive(1, 2'd2, 2'd0, 2'd1, 0, 0, 5'd0, 64'hFFFF, 64'd1, 0, 0, 0);
        drive(1, 2'd2, 2'd3, 2'd0, 0, 0, 5'd1, 64'd1, 64'd1, 0, 0, 0);
        drive(0, 2'd0, 2'd0, 2'd0, 0, 1, 5'd1, 64'd1, 64'd1, 0, 0, 1);

        for (int i = 0; i < 4000; i++) begin
            drive(($urandom % 8) != 0, 2'($urandom), 2'($urandom % 7 == 0 ? 3 : $urandom % 3),
                  2'($urandom), ($urandom % 5) == 0, 1'($urandom), 5'($urandom % 4),
                  {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                  5'($urandom), 1'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule